// File: doc/BRIEF.md
# Bufferless Deflection Router Core

This block is the switching core of a four-port mesh router that holds no flits. Each port (north, east, south, west) can deliver one flit per cycle. Every flit that arrives is sent out again on exactly one output, two clock cycles later. A flit that cannot reach a useful output is deflected onto a free one instead of being stalled.

Each flit carries a signed X offset and a signed Y offset to its destination, an age and a payload. The core ranks the flits present in a cycle by age. Each flit, in rank order, takes the first free output that brings it closer to its destination. If none is free, it takes the lowest-numbered free output. Because there are as many outputs as inputs, a free output always remains. On the way out, the header is rewritten to match the output actually taken, and the age grows by one.

Each port has a valid bit but no ready. The core never applies back-pressure, because it can always accept a flit. Downstream logic must accept every valid output flit in the cycle it appears.

Top module: `deflect_router`

## Requirements
- R1: Every valid input flit appears on exactly one output exactly two cycles after it is presented, so the number of valid outputs equals the number of valid inputs two cycles earlier.
- R2: Nothing is held back. An output is valid only in the cycle that carries a flit presented two cycles earlier, so a cycle after idle inputs shows all outputs invalid.
- R3: Flits pick outputs in priority order. A larger age comes first, and equal ages are ordered by input index, with north=0, east=1, south=2 and west=3 (lower index first).
- R4: A flit prefers its X direction first and then its Y direction, if that output is still free. Positive X means east and negative X means west. Positive Y means north and negative Y means south.
- R5: A flit with no free productive output, including a flit whose two offsets are both zero, takes the lowest-numbered free output.
- R6: The offsets leave matching the output taken:
  - leaving east decrements X and leaving west increments X;
  - leaving north decrements Y and leaving south increments Y;
  - the other offset is unchanged;
  - each update saturates at the signed range limits.
- R7: The age field on every output flit is the input age plus one, saturating at its maximum value.
- R8: The payload passes unchanged. The flit layout from bit 0 upward is X offset (OFF_W bits), Y offset (OFF_W bits), age (AGE_W bits) and payload (DATA_W bits). Offsets are two's complement.
- R9: While reset is held, and in the first cycles after it, all outputs are invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 4 | Flit present per input port (bit 0 north, 1 east, 2 south, 3 west) |
| in_flit | input | 4*FLIT_W | Input flits, port p in slice p*FLIT_W |
| out_valid | output | 4 | Flit present per output port (same port numbering) |
| out_flit | output | 4*FLIT_W | Output flits, port p in slice p*FLIT_W |

## Verification
Productive routing and deflection fall in the same cycle whenever two or more flits want the same output. In that cycle the winner is decided by age and input index, and the losers are pushed onto leftover ports. The bench provokes this with sweeps that present every subset of valid inputs. The headers in those sweeps include repeated directions, tied and saturated ages, and offsets at the signed extremes. Each output port's valid bit, offsets, age and payload are compared against an arithmetic reference that ranks and places the flits in the bench.

// File: rtl/deflect_pkg.sv
package deflect_pkg;
  localparam int NPORTS = 4;
  typedef enum logic [1:0] {
    PORT_N = 2'd0,
    PORT_E = 2'd1,
    PORT_S = 2'd2,
    PORT_W = 2'd3
  } port_e;
endpackage

// File: rtl/dr_route.sv
// Productive direction decode for one flit header.
module dr_route #(
  parameter int OFF_W = 4
) (
  input  logic [OFF_W-1:0] dx,
  input  logic [OFF_W-1:0] dy,
  output logic [3:0]       want_x,
  output logic [3:0]       want_y
);
  import deflect_pkg::*;
  logic x_zero, y_zero;
  assign x_zero = (dx == '0);
  assign y_zero = (dy == '0);

  always_comb begin
    want_x = '0;
    want_y = '0;
    if (!x_zero) begin
      if (dx[OFF_W-1]) want_x[PORT_W] = 1'b1;
      else             want_x[PORT_E] = 1'b1;
    end
    if (!y_zero) begin
      if (dy[OFF_W-1]) want_y[PORT_S] = 1'b1;
      else             want_y[PORT_N] = 1'b1;
    end
  end
endmodule

// File: rtl/dr_rank.sv
// Ranks valid flits: older first, lower input index on a tie.
module dr_rank #(
  parameter int NP    = 4,
  parameter int AGE_W = 4
) (
  input  logic [NP-1:0]       valid,
  input  logic [NP*AGE_W-1:0] ages,
  output logic [NP*NP-1:0]    order_oh  // bit r*NP+i : input i holds rank r
);
  localparam int RANK_W = $clog2(NP) + 1;

  for (genvar i = 0; i < NP; i++) begin : g_in
    logic [RANK_W-1:0] rank;
    always_comb begin
      rank = '0;
      for (int j = 0; j < NP; j++) begin
        if (j != i && valid[j]) begin
          if (ages[j*AGE_W +: AGE_W] > ages[i*AGE_W +: AGE_W])
            rank = rank + 1'b1;
          else if (ages[j*AGE_W +: AGE_W] == ages[i*AGE_W +: AGE_W] && j < i)
            rank = rank + 1'b1;
        end
      end
    end
    for (genvar r = 0; r < NP; r++) begin : g_slot
      assign order_oh[r*NP+i] = valid[i] && (rank == RANK_W'(r));
    end
  end
endmodule

// File: rtl/dr_alloc.sv
// Serial output assignment in rank order.
module dr_alloc #(
  parameter int NP = 4
) (
  input  logic [NP-1:0]    valid,
  input  logic [NP*NP-1:0] order_oh,
  input  logic [NP*NP-1:0] want_x,
  input  logic [NP*NP-1:0] want_y,
  output logic [NP*NP-1:0] grant     // bit i*NP+o : input i leaves on output o
);
  logic [NP-1:0] free;
  logic [NP-1:0] pick;
  logic [NP-1:0] hit_x, hit_y;
  logic          found;

  always_comb begin
    free  = '1;
    grant = '0;
    pick  = '0;
    hit_x = '0;
    hit_y = '0;
    found = 1'b0;
    for (int r = 0; r < NP; r++) begin
      for (int i = 0; i < NP; i++) begin
        if (valid[i] && order_oh[r*NP+i]) begin
          pick  = '0;
          hit_x = want_x[i*NP +: NP] & free;
          hit_y = want_y[i*NP +: NP] & free;
          if (|hit_x)      pick = hit_x;
          else if (|hit_y) pick = hit_y;
          else begin
            found = 1'b0;
            for (int o = 0; o < NP; o++) begin
              if (!found && free[o]) begin
                pick[o] = 1'b1;
                found   = 1'b1;
              end
            end
          end
          grant[i*NP +: NP] = pick;
          free = free & ~pick;
        end
      end
    end
  end
endmodule

// File: rtl/dr_hop.sv
// Header rewrite for a flit leaving on output PORT.
module dr_hop #(
  parameter int DATA_W = 8,
  parameter int OFF_W  = 4,
  parameter int AGE_W  = 4,
  parameter int PORT   = 0,
  localparam int FLIT_W = DATA_W + AGE_W + 2*OFF_W
) (
  input  logic [FLIT_W-1:0] flit_in,
  output logic [FLIT_W-1:0] flit_out
);
  import deflect_pkg::*;
  localparam logic [OFF_W-1:0] OMAX = {1'b0, {(OFF_W-1){1'b1}}};
  localparam logic [OFF_W-1:0] OMIN = {1'b1, {(OFF_W-1){1'b0}}};
  localparam logic [AGE_W-1:0] AMAX = '1;

  logic [OFF_W-1:0]  dx, dy, dx_n, dy_n;
  logic [AGE_W-1:0]  age, age_n;
  logic [DATA_W-1:0] data;

  assign dx   = flit_in[0 +: OFF_W];
  assign dy   = flit_in[OFF_W +: OFF_W];
  assign age  = flit_in[2*OFF_W +: AGE_W];
  assign data = flit_in[2*OFF_W+AGE_W +: DATA_W];

  always_comb begin
    dx_n = dx;
    dy_n = dy;
    if (PORT == int'(PORT_E) && dx != OMIN) dx_n = dx - 1'b1;
    if (PORT == int'(PORT_W) && dx != OMAX) dx_n = dx + 1'b1;
    if (PORT == int'(PORT_N) && dy != OMIN) dy_n = dy - 1'b1;
    if (PORT == int'(PORT_S) && dy != OMAX) dy_n = dy + 1'b1;
    age_n = (age == AMAX) ? age : age + 1'b1;
  end

  assign flit_out = {data, age_n, dy_n, dx_n};
endmodule

// File: rtl/deflect_router.sv
module deflect_router #(
  parameter int DATA_W = 8,
  parameter int OFF_W  = 4,
  parameter int AGE_W  = 4,
  localparam int FLIT_W = DATA_W + AGE_W + 2*OFF_W,
  localparam int NP     = deflect_pkg::NPORTS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NP-1:0]        in_valid,
  input  logic [NP*FLIT_W-1:0] in_flit,
  output logic [NP-1:0]        out_valid,
  output logic [NP*FLIT_W-1:0] out_flit
);
  logic [NP-1:0]        in_v_q;
  logic [NP*FLIT_W-1:0] in_f_q;
  logic [NP*AGE_W-1:0]  ages;
  logic [NP*NP-1:0]     want_x, want_y, order_oh, grant;
  logic [NP-1:0]        out_v_d;
  logic [NP*FLIT_W-1:0] out_f_d;

  // input stage
  always_ff @(posedge clk) begin
    if (rst) begin
      in_v_q <= '0;
      in_f_q <= '0;
    end else begin
      in_v_q <= in_valid;
      in_f_q <= in_flit;
    end
  end

  for (genvar i = 0; i < NP; i++) begin : g_dec
    assign ages[i*AGE_W +: AGE_W] = in_f_q[i*FLIT_W + 2*OFF_W +: AGE_W];
    dr_route #(.OFF_W(OFF_W)) u_route (
      .dx     (in_f_q[i*FLIT_W +: OFF_W]),
      .dy     (in_f_q[i*FLIT_W + OFF_W +: OFF_W]),
      .want_x (want_x[i*NP +: NP]),
      .want_y (want_y[i*NP +: NP])
    );
  end

  dr_rank #(.NP(NP), .AGE_W(AGE_W)) u_rank (
    .valid    (in_v_q),
    .ages     (ages),
    .order_oh (order_oh)
  );

  dr_alloc #(.NP(NP)) u_alloc (
    .valid    (in_v_q),
    .order_oh (order_oh),
    .want_x   (want_x),
    .want_y   (want_y),
    .grant    (grant)
  );

  for (genvar o = 0; o < NP; o++) begin : g_out
    logic [FLIT_W-1:0] sel_flit;
    logic              sel_v;
    always_comb begin
      sel_flit = '0;
      sel_v    = 1'b0;
      for (int i = 0; i < NP; i++) begin
        if (grant[i*NP+o]) begin
          sel_flit = sel_flit | in_f_q[i*FLIT_W +: FLIT_W];
          sel_v    = 1'b1;
        end
      end
    end
    assign out_v_d[o] = sel_v;
    dr_hop #(.DATA_W(DATA_W), .OFF_W(OFF_W), .AGE_W(AGE_W), .PORT(o)) u_hop (
      .flit_in  (sel_flit),
      .flit_out (out_f_d[o*FLIT_W +: FLIT_W])
    );
  end

  // output stage
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= '0;
      out_flit  <= '0;
    end else begin
      out_valid <= out_v_d;
      out_flit  <= out_f_d;
    end
  end
endmodule

// File: rtl/dr_checker.sv
module dr_checker #(
  parameter int FLIT_W = 20,
  parameter int OFF_W  = 4,
  parameter int AGE_W  = 4,
  parameter int NP     = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NP-1:0]        stage_v,
  input logic [NP*NP-1:0]     grant,
  input logic [NP-1:0]        out_valid,
  input logic [NP*FLIT_W-1:0] out_flit
);
  // R1: no flit lost or duplicated across the allocation stage
  a_r1_conserve: assert property (@(posedge clk) disable iff (rst)
    $countones(out_valid) == $past($countones(stage_v)));

  // R9: first cycle after reset shows nothing
  a_r9_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> out_valid == '0);

  for (genvar i = 0; i < NP; i++) begin : g_row
    // R1: each valid staged flit receives exactly one output
    a_r1_one_exit: assert property (@(posedge clk) disable iff (rst)
      stage_v[i] |-> $countones(grant[i*NP +: NP]) == 1);
    // R2: an empty stage slot claims no output
    a_r2_no_ghost: assert property (@(posedge clk) disable iff (rst)
      !stage_v[i] |-> grant[i*NP +: NP] == '0);
  end

  for (genvar o = 0; o < NP; o++) begin : g_col
    logic [NP-1:0] col;
    for (genvar i = 0; i < NP; i++) begin : g_bit
      assign col[i] = grant[i*NP+o];
    end
    // R3: an output is never shared
    a_r3_single_owner: assert property (@(posedge clk) disable iff (rst)
      $onehot0(col));
    // R7: a flit that has taken a hop never leaves with age zero
    a_r7_age_nonzero: assert property (@(posedge clk) disable iff (rst)
      out_valid[o] |-> out_flit[o*FLIT_W + 2*OFF_W +: AGE_W] != '0);
  end
endmodule

bind deflect_router dr_checker #(
  .FLIT_W (FLIT_W),
  .OFF_W  (OFF_W),
  .AGE_W  (AGE_W),
  .NP     (NP)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .stage_v   (in_v_q),
  .grant     (grant),
  .out_valid (out_valid),
  .out_flit  (out_flit)
);

// File: tb/tb_deflect_router.sv
module tb_deflect_router;
  localparam int DATA_W = 8;
  localparam int OFF_W  = 4;
  localparam int AGE_W  = 4;
  localparam int FLIT_W = DATA_W + AGE_W + 2*OFF_W;
  localparam int NP     = 4;
  localparam int OLIM   = 7;   // signed offset limits -8..7
  localparam int AMAXV  = 15;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [NP-1:0]        in_valid = '0;
  logic [NP*FLIT_W-1:0] in_flit = '0;
  logic [NP-1:0]        out_valid;
  logic [NP*FLIT_W-1:0] out_flit;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // stimulus and expectations
  int s_v[NP], s_dx[NP], s_dy[NP], s_age[NP], s_dat[NP];
  int e_v[NP], e_dx[NP], e_dy[NP], e_age[NP], e_dat[NP];

  deflect_router #(.DATA_W(DATA_W), .OFF_W(OFF_W), .AGE_W(AGE_W)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_flit(in_flit),
    .out_valid(out_valid), .out_flit(out_flit)
  );

  always #10 clk = ~clk;  // 50 MHz

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual cycles %0d expected below 100000", cycles);
      finish_run();
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int sext(input int v);
    return (v >= 8) ? v - 16 : v;
  endfunction

  // Reference: rank by age (ties to lower index), place X, Y, then lowest free.
  task automatic model();
    int served[NP];
    int free[NP];
    int pick, best, port;
    for (int k = 0; k < NP; k++) begin
      served[k] = 0; free[k] = 1; e_v[k] = 0;
      e_dx[k] = 0; e_dy[k] = 0; e_age[k] = 0; e_dat[k] = 0;
    end
    for (int r = 0; r < NP; r++) begin
      best = -1;
      for (int i = 0; i < NP; i++)
        if (s_v[i] && !served[i] && (best < 0 || s_age[i] > s_age[best])) best = i;
      if (best >= 0) begin
        served[best] = 1;
        port = -1;
        if (s_dx[best] > 0 && free[1]) port = 1;
        else if (s_dx[best] < 0 && free[3]) port = 3;
        if (port < 0) begin
          if (s_dy[best] > 0 && free[0]) port = 0;
          else if (s_dy[best] < 0 && free[2]) port = 2;
        end
        if (port < 0) begin
          pick = -1;
          for (int o = NP-1; o >= 0; o--) if (free[o]) pick = o;
          port = pick;
        end
        free[port] = 0;
        e_v[port]   = 1;
        e_dx[port]  = s_dx[best];
        e_dy[port]  = s_dy[best];
        if (port == 1 && e_dx[port] > -OLIM-1) e_dx[port]--;
        if (port == 3 && e_dx[port] < OLIM)    e_dx[port]++;
        if (port == 0 && e_dy[port] > -OLIM-1) e_dy[port]--;
        if (port == 2 && e_dy[port] < OLIM)    e_dy[port]++;
        e_age[port] = (s_age[best] < AMAXV) ? s_age[best] + 1 : AMAXV;
        e_dat[port] = s_dat[best];
      end
    end
  endtask

  task automatic drive();
    for (int i = 0; i < NP; i++) begin
      in_valid[i] = s_v[i][0];
      in_flit[i*FLIT_W +: FLIT_W] = {DATA_W'(s_dat[i]), AGE_W'(s_age[i]),
                                     OFF_W'(s_dy[i]), OFF_W'(s_dx[i])};
    end
  endtask

  task automatic compare();
    logic [FLIT_W-1:0] f;
    for (int o = 0; o < NP; o++) begin
      f = out_flit[o*FLIT_W +: FLIT_W];
      check($sformatf("R1 R2 valid port %0d", o), int'(out_valid[o]), e_v[o]);
      if (e_v[o] && out_valid[o]) begin
        check($sformatf("R3 R4 R5 R6 dx port %0d", o), sext(int'(f[0 +: OFF_W])), e_dx[o]);
        check($sformatf("R3 R4 R5 R6 dy port %0d", o), sext(int'(f[OFF_W +: OFF_W])), e_dy[o]);
        check($sformatf("R7 age port %0d", o), int'(f[2*OFF_W +: AGE_W]), e_age[o]);
        check($sformatf("R8 payload port %0d", o), int'(f[2*OFF_W+AGE_W +: DATA_W]), e_dat[o]);
      end
    end
  endtask

  // one vector: present, idle, check result, check emptiness afterwards
  task automatic apply();
    @(negedge clk);
    drive();
    model();
    @(negedge clk);
    in_valid = '0;
    @(negedge clk);
    compare();
    @(negedge clk);
    check("R2 idle follow-up", int'(out_valid), 0);
  endtask

  initial begin
    // R9: outputs idle during and right after reset
    repeat (3) @(negedge clk);
    check("R9 during reset", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R9 after reset", int'(out_valid), 0);

    // Directed: two flits both east, equal age; north (index 0) wins (R3, R4),
    // east input deflected via its Y wish north (R4).
    for (int i = 0; i < NP; i++) begin
      s_v[i] = 0; s_dx[i] = 0; s_dy[i] = 0; s_age[i] = 0; s_dat[i] = 0;
    end
    s_v[0] = 1; s_dx[0] = 3; s_age[0] = 5; s_dat[0] = 8'hA1;
    s_v[1] = 1; s_dx[1] = 2; s_dy[1] = 1; s_age[1] = 5; s_dat[1] = 8'hB2;
    apply();
    // Directed: saturation of offsets and age under deflection (R5, R6, R7)
    for (int i = 0; i < NP; i++) begin
      s_v[i] = 1; s_dx[i] = 7; s_dy[i] = -8; s_age[i] = 15 - i; s_dat[i] = i;
    end
    apply();
    // Directed: arrived flits (zero offsets) take lowest free outputs (R5)
    for (int i = 0; i < NP; i++) begin
      s_v[i] = (i != 1); s_dx[i] = 0; s_dy[i] = 0; s_age[i] = i; s_dat[i] = 40 + i;
    end
    apply();

    // Sweep: every valid subset against varied headers
    for (int mask = 0; mask < 16; mask++) begin
      for (int seed = 0; seed < 64; seed++) begin
        for (int i = 0; i < NP; i++) begin
          s_v[i]  = (mask >> i) & 1;
          s_dx[i] = ((seed*5 + i*3 + mask) % 16) - 8;
          s_dy[i] = ((seed*7 + i*11 + mask*3) % 16) - 8;
          if (seed % 8 == 1) s_dx[i] = 5;           // all contend for east
          if (seed % 8 == 2) begin s_dx[i] = 0; s_dy[i] = -3; end
          s_age[i] = (seed % 4 == 0) ? 3 : ((seed*3 + i*5) % 16);
          s_dat[i] = (mask*16 + seed*4 + i) % 256;
        end
        apply();
      end
    end
    finish_run();
  end
endmodule